// File: doc/BRIEF.md
# BF16 Block Floating-Point Aligner

This block turns a stream of BF16 numbers into block fixed-point. Each input beat carries 16 BF16 words. Beats are taken in pairs, and the two beats of a pair form one 32-element block. The block finds the largest exponent in that block. It then rewrites every element as a 27-bit two's-complement mantissa that is scaled to the shared exponent. A downstream engine can then add or multiply the elements as plain integers that share one scale factor.

The input is a stream slave whose ready output is always high, so the block never stalls its source. The exponent maximum is built in two steps. The first beat of a pair is registered together with its own maximum. When the second beat arrives, that stored maximum is combined with the maximum of the second beat. The finished block is held in a register of its own while the next pair is collected.

Sixteen lane shifters handle the held block in two halves on consecutive clocks. The result leaves through a registered 432-bit output carrying 16 lanes of 27 bits each. Continuous input with no idle cycles is sustained without loss.

Top module: `bf16_block_aligner`

## Requirements
- R1: `in_ready` is 1 in every cycle, including during and after reset.
- R2: Only cycles with `in_valid` high count as beats. Beats alternate first/second starting with the first after reset, and cycles with `in_valid` low neither advance the pairing nor disturb stored data, whatever is on `in_data`.
- R3: The shared exponent is the largest 8-bit exponent field (bits 14:7 of an element) among the 32 elements of the block. An element whose exponent field is 0 converts to 0 regardless of sign and fraction, and it takes no part in the search.
- R4: A nonzero element with exponent e is converted as follows. Build a 27-bit value with bit 26 = 0, bit 25 = 1 and bits 24:18 = the element's 7-bit fraction (element bits 6:0), with all lower bits 0. Shift this value right logically by (shared exponent − e).
- R5: If the element's sign bit (bit 15) is 1, the lane carries the two's-complement negation of the shifted value. Every nonzero lane result therefore has bit 26 equal to the element's sign.
- R6: When (shared exponent − e) is 27 or more, the lane result is 0. This covers differences of 32 and above.
- R7: Each block produces exactly two output beats with `out_valid` high, on consecutive clocks. The first beat carries elements 0–15 (the first input beat) and the second carries elements 16–31. The first beat appears on the third rising edge counted from (and including) the edge that accepts the block's second input beat. In every other cycle `out_valid` is low.
- R8: `out_data` changes only on edges that present an output beat. In cycles with `out_valid` low it keeps the last output value.
- R9: Blocks presented back to back at the full rate of one beat per clock, with no idle cycles, all convert correctly.
- R10: During reset and after it, until the first output beat, `out_valid` is 0 and `out_data` is all zeros.
- R11: Element i of an input beat occupies `in_data[16*i+15:16*i]`. Lane i of an output beat occupies `out_data[27*i+26:27*i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | 256 | Sixteen BF16 elements of one beat |
| in_valid | input | 1 | Beat present on `in_data` |
| in_ready | output | 1 | Always 1; no backpressure |
| out_data | output | 432 | Sixteen 27-bit fixed-point lanes |
| out_valid | output | 1 | Output beat present on `out_data` |

## Verification
There are three registers between a block's second beat and the output. The first output beat is therefore due at the sampling point two clocks after the edge that accepts the second beat, and the second output beat is due one clock later. The first beat of a pair sets no timing of its own, however many idle cycles follow it. The bench notes the cycle number at which it drives each second beat and queues both expected output beats with due cycles of that number plus 3 and plus 4. It samples at the falling edge, checking the queued beat exactly in its due cycle. In every other cycle it requires `out_valid` low and `out_data` unchanged from the last beat.

// File: rtl/bfa_pkg.sv
package bfa_pkg;

  localparam int BfExpW   = 8;
  localparam int BfFracW  = 7;
  localparam int FixW     = 27;
  localparam int BeatLanes = 16;

  // strobes issued by the sequencer to the datapath
  typedef struct packed {
    logic loadLow;    // capture first beat of a pair
    logic loadBlock;  // capture second beat, close block
    logic shiftEn;    // shift stage captures a half-block
    logic shiftHi;    // selects elements of the second beat
    logic outLoad;    // output register captures shift stage
  } bfa_strobe_t;

endpackage

// File: rtl/bfa_lane.sv
module bfa_lane #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 7,
  parameter int FIX_W  = 27
) (
  input  logic [EXP_W+FRAC_W:0] elem,
  input  logic [EXP_W-1:0]      blkMax,
  output logic [FIX_W-1:0]      res
);

  localparam int SH_W = $clog2(FIX_W);
  localparam int HID_POS = FIX_W - 2;
  localparam logic [EXP_W-1:0] FLUSH_AT = EXP_W'(FIX_W);

  logic              sgn;
  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] frac;
  logic [EXP_W-1:0]  diff;
  logic [SH_W-1:0]   shAmt;
  logic [FIX_W-1:0]  seed;
  logic [FIX_W-1:0]  shifted;
  logic              flush;

  assign sgn      = elem[EXP_W+FRAC_W];
  assign expField = elem[FRAC_W +: EXP_W];
  assign frac     = elem[FRAC_W-1:0];

  // blkMax is never below a participating exponent
  assign diff  = blkMax - expField;
  assign shAmt = diff[SH_W-1:0];
  assign flush = (expField == '0) || (diff >= FLUSH_AT);

  always_comb begin
    seed = '0;
    seed[HID_POS] = 1'b1;
    seed[HID_POS-1 -: FRAC_W] = frac;
  end

  assign shifted = seed >> shAmt;

  always_comb begin
    if (flush)    res = '0;
    else if (sgn) res = -shifted;
    else          res = shifted;
  end

endmodule

// File: rtl/bfa_ctrl.sv
module bfa_ctrl
  import bfa_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  output bfa_strobe_t strb,
  output logic        outValid
);

  logic phase;       // 0: expecting first beat of a pair
  logic startShift;  // block register freshly loaded
  logic pendHi;      // second half still to shift
  logic shiftValid;  // shift register holds a half-block

  always_comb begin
    strb.loadLow   = inValid & ~phase;
    strb.loadBlock = inValid & phase;
    strb.shiftEn   = startShift | pendHi;
    strb.shiftHi   = pendHi;
    strb.outLoad   = shiftValid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= 1'b0;
      startShift <= 1'b0;
      pendHi     <= 1'b0;
      shiftValid <= 1'b0;
      outValid   <= 1'b0;
    end else begin
      phase      <= phase ^ inValid;
      startShift <= strb.loadBlock;
      pendHi     <= startShift;
      shiftValid <= strb.shiftEn;
      outValid   <= shiftValid;
    end
  end

  // a new block can never land while the previous one still needs its second half
  assert_shift_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({startShift, pendHi}));

  // output beats arrive in pairs
  assert_half_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outValid) |=> outValid);

endmodule

// File: rtl/bfa_datapath.sv
module bfa_datapath
  import bfa_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 7,
  parameter int FIX_W  = 27
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  bfa_strobe_t             strb,
  input  logic [LANES*(1+EXP_W+FRAC_W)-1:0] inData,
  output logic [LANES*FIX_W-1:0]  outData
);

  localparam int ELEM_W = 1 + EXP_W + FRAC_W;
  localparam int IN_W   = LANES * ELEM_W;
  localparam int OUT_W  = LANES * FIX_W;

  function automatic logic [EXP_W-1:0] beatMax(input logic [IN_W-1:0] b);
    logic [EXP_W-1:0] m;
    m = '0;
    for (int i = 0; i < LANES; i++) begin
      if (b[i*ELEM_W + FRAC_W +: EXP_W] > m) m = b[i*ELEM_W + FRAC_W +: EXP_W];
    end
    return m;
  endfunction

  // stage 1: pairing and exponent maximum
  logic [IN_W-1:0]  lowBuf;
  logic [EXP_W-1:0] lowMax;
  logic [IN_W-1:0]  blkLo, blkHi;
  logic [EXP_W-1:0] blkMax;
  logic [EXP_W-1:0] inMax;

  assign inMax = beatMax(inData);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowBuf <= '0;
      lowMax <= '0;
      blkLo  <= '0;
      blkHi  <= '0;
      blkMax <= '0;
    end else begin
      if (strb.loadLow) begin
        lowBuf <= inData;
        lowMax <= inMax;
      end
      if (strb.loadBlock) begin
        blkLo  <= lowBuf;
        blkHi  <= inData;
        blkMax <= (lowMax > inMax) ? lowMax : inMax;
      end
    end
  end

  // stage 2: per-lane alignment, one half-block per clock
  logic [IN_W-1:0]  halfSel;
  logic [FIX_W-1:0] laneRes [LANES];
  logic [OUT_W-1:0] shiftData;

  assign halfSel = strb.shiftHi ? blkHi : blkLo;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ELEM_W-1:0] elem;
    assign elem = halfSel[g*ELEM_W +: ELEM_W];

    bfa_lane #(
      .EXP_W (EXP_W),
      .FRAC_W(FRAC_W),
      .FIX_W (FIX_W)
    ) u_lane (
      .elem  (elem),
      .blkMax(blkMax),
      .res   (laneRes[g])
    );

    // nonzero lane result carries the element sign in its top bit
    assert_sign_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (strb.shiftEn && laneRes[g] != '0) |-> (laneRes[g][FIX_W-1] == elem[ELEM_W-1]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shiftData <= '0;
    end else if (strb.shiftEn) begin
      for (int i = 0; i < LANES; i++) shiftData[i*FIX_W +: FIX_W] <= laneRes[i];
    end
  end

  // stage 3: output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            outData <= '0;
    else if (strb.outLoad) outData <= shiftData;
  end

endmodule

// File: rtl/bf16_block_aligner.sv
module bf16_block_aligner
  import bfa_pkg::*;
#(
  parameter int LANES  = BeatLanes,
  parameter int EXP_W  = BfExpW,
  parameter int FRAC_W = BfFracW,
  parameter int FIX_W  = FixW
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [LANES*(1+EXP_W+FRAC_W)-1:0]     in_data,
  input  logic                                  in_valid,
  output logic                                  in_ready,
  output logic [LANES*FIX_W-1:0]                out_data,
  output logic                                  out_valid
);

  bfa_strobe_t strb;

  assign in_ready = 1'b1;

  bfa_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (in_valid),
    .strb    (strb),
    .outValid(out_valid)
  );

  bfa_datapath #(
    .LANES (LANES),
    .EXP_W (EXP_W),
    .FRAC_W(FRAC_W),
    .FIX_W (FIX_W)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .inData (in_data),
    .outData(out_data)
  );

  // idle cycles leave the output untouched
  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));

endmodule

// File: tb/bf16_block_aligner_bench.sv
module bf16_block_aligner_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] in_data = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [431:0] out_data;
  logic         out_valid;

  always #2 clk = ~clk;

  bf16_block_aligner u_bf16_block_aligner (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_data  (in_data),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_data (out_data),
    .out_valid(out_valid)
  );

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit monOn = 1'b0;

  logic [431:0] expQ[$];
  int           dueQ[$];
  string        tagQ[$];
  logic [431:0] lastOut = '0;
  logic [15:0]  blk [32];

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input logic [431:0] act, input logic [431:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  // reference conversion straight from R3..R6
  function automatic logic [26:0] refLane(input logic [15:0] e, input int emax);
    int ex;
    int d;
    logic [26:0] m;
    ex = int'(e[14:7]);
    if (ex == 0) return '0;
    d = emax - ex;
    if (d >= 27) return '0;
    m = 27'(1 << 25) | (27'(e[6:0]) << 18);
    m = m >> d;
    if (e[15]) m = -m;
    return m;
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data = {8{$urandom}};
    end
  endtask

  task automatic sendBlock(input int gapMid, input int gapAfter, input string tag);
    logic [255:0] lo, hi;
    logic [431:0] h0, h1;
    int emax;
    emax = 0;
    for (int k = 0; k < 32; k++)
      if (int'(blk[k][14:7]) > emax) emax = int'(blk[k][14:7]);
    for (int i = 0; i < 16; i++) begin
      lo[16*i +: 16] = blk[i];
      hi[16*i +: 16] = blk[16+i];
      h0[27*i +: 27] = refLane(blk[i], emax);
      h1[27*i +: 27] = refLane(blk[16+i], emax);
    end
    @(negedge clk);
    in_data = lo;
    in_valid = 1'b1;
    idle(gapMid);
    @(negedge clk);
    in_data = hi;
    in_valid = 1'b1;
    expQ.push_back(h0); dueQ.push_back(cyc + 3); tagQ.push_back(tag);
    expQ.push_back(h1); dueQ.push_back(cyc + 4); tagQ.push_back(tag);
    idle(gapAfter);
  endtask

  // output monitor: R7 timing, R8 hold, R1 ready
  always @(negedge clk) begin
    if (monOn) begin
      chk(in_ready === 1'b1, "R1 ready", {431'b0, in_ready}, 432'd1);
      if (dueQ.size() > 0 && dueQ[0] == cyc) begin
        chk(out_valid === 1'b1, {"R7 valid ", tagQ[0]}, {431'b0, out_valid}, 432'd1);
        chk(out_data === expQ[0], {"R4 R11 data ", tagQ[0]}, out_data, expQ[0]);
        lastOut = expQ[0];
        void'(expQ.pop_front());
        void'(dueQ.pop_front());
        void'(tagQ.pop_front());
      end else begin
        chk(out_valid === 1'b0, "R7 idle valid", {431'b0, out_valid}, 432'd0);
        chk(out_data === lastOut, "R8 hold", out_data, lastOut);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at cyc=%0d", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (4) @(negedge clk);
    chk(out_valid === 1'b0, "R10 reset valid", {431'b0, out_valid}, 432'd0);
    chk(out_data === '0, "R10 reset data", out_data, '0);
    chk(in_ready === 1'b1, "R1 in reset", {431'b0, in_ready}, 432'd1);
    rst_n = 1'b1;
    monOn = 1'b1;
    idle(3);

    // R4 R5 R6: exponent-difference sweep, maximum moved across both beats
    for (int d = 0; d < 45; d++) begin
      int p;
      p = (d * 5) % 32;
      for (int k = 0; k < 32; k++) begin
        int ex;
        ex = 140 - ((d + k) % 45);
        if ((k + d) % 11 == 5) ex = 0;
        if (k == p) ex = 140;
        blk[k] = {1'(((k + d) % 3) == 0), 8'(ex), 7'((d * 7 + k * 13) & 127)};
      end
      sendBlock(d % 3, d % 2, "R4 R5 R6 sweep");
    end

    // R3: all elements zero, negative zero, zero exponent with fraction
    for (int k = 0; k < 32; k++) blk[k] = (k % 3 == 0) ? 16'h8000 : (k % 3 == 1) ? 16'h0000 : 16'h007F;
    sendBlock(0, 2, "R3 all zero");

    // R3 R6: single maximum at boundary positions, others at distance 25..27
    for (int q = 0; q < 4; q++) begin
      int p;
      p = (q == 0) ? 0 : (q == 1) ? 15 : (q == 2) ? 16 : 31;
      for (int k = 0; k < 32; k++)
        blk[k] = {1'(k[0]), 8'(100 - (25 + k % 3)), 7'(k * 3)};
      blk[p] = {1'(q[0]), 8'd100, 7'h41};
      blk[(p + 7) % 32] = 16'h0000;
      sendBlock(q, 1, "R3 R6 boundary");
    end

    // R2: random gaps with noise on the bus while idle
    for (int b = 0; b < 30; b++) begin
      for (int k = 0; k < 32; k++) blk[k] = 16'($urandom);
      sendBlock(int'($urandom % 4), int'($urandom % 4), "R2 gaps");
    end

    // R9: full-rate back-to-back blocks
    for (int b = 0; b < 150; b++) begin
      for (int k = 0; k < 32; k++) blk[k] = 16'($urandom);
      sendBlock(0, 0, "R9 full rate");
    end

    idle(12);
    chk(dueQ.size() == 0, "R7 all beats seen", 432'(dueQ.size()), 432'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule